// File: doc/BRIEF.md
# Delayed Sticky Freeze Trigger

This block decides when a capture system should stop recording. A small set of trigger sources (a local error line, a lost-lock line and a freeze command arriving from a remote controller) is qualified by a per-source enable mask. Any enabled source that is high sets a sticky trigger flag. Once set, the flag stays set until the host clears it. The flag can also be set or cleared directly by a host write.

While the flag is set, a one-shot down counter, stepped by a microsecond tick derived from the system clock, holds off the active-low freeze output. This lets the capture window be moved around the moment of the error. When the counter reaches zero it stops there, and the freeze output is asserted for as long as the flag stays set. The delay has no further effect until the host loads a new count.

A two-register host port writes the mask, the flag and the delay count, and reads back the mask, the flag and the live counter. The source inputs arrive as active-high, already-synchronous levels. Bus decoding and line drivers sit outside the block.

Top module: `frz_trig_top`

## Requirements
- R1: After reset the flag is clear, the mask is all zeros, the delay counter is zero and `freeze_n` is high.
- R2: If any source is high while its mask bit is 1 and no control write occurs, the flag is set on the next clock edge.
- R3: A source whose mask bit is 0 has no effect on the flag, the counter or `freeze_n`.
- R4: The flag stays set after all sources go low, until a control write with bit 0 = 0.
- R5: A write to the control register (address 0) loads the flag from data bit 0 and the mask from data bits 3..1, where bit 1 enables source 0, bit 2 enables source 1 and bit 3 enables source 2. This write takes priority over the sources in the same cycle. Writing all zeros therefore clears the flag and disables every source.
- R6: A write to the delay register (address 1) loads the 16-bit counter with data bits 15..0. The load takes priority over decrementing.
- R7: The counter decrements by one on each microsecond tick, once every TICK_DIV clocks, and only while the flag is set. Otherwise it holds its value.
- R8: The counter stops at zero and stays there until the host writes a new count.
- R9: `freeze_n` is low exactly when the flag is set and the counter is zero. A zero delay therefore freezes in the same cycle that the flag becomes visible. The delay also applies when the flag was set by a host write.
- R10: Reading address 0 returns the flag in bit 0 and the mask in bits 3..1, with all other bits zero. Reading address 1 returns the live counter. Readback is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_src_i | input | NSRC (3) | Active-high trigger sources: bit 0 local error, bit 1 lost lock, bit 2 remote freeze command |
| host_wr_i | input | 1 | Host write strobe, one cycle per write |
| host_addr_i | input | 1 | Register select: 0 control, 1 delay |
| host_wdata_i | input | DATA_W (16) | Host write data |
| host_rdata_o | output | DATA_W (16) | Readback of the selected register |
| freeze_n_o | output | 1 | Active-low freeze output |

## Verification
The hardest case to reach is a counter that is decrementing while the flag is set and is then reloaded, together with a control write that clears the flag in the same cycle as an enabled source. The bench gets there by loading nonzero delays before arming, letting several ticks go by, and then reloading the counter while the flag is still set. It also issues clearing writes while an enabled source is held high. A long pseudo-random phase then mixes sparse source pulses, control writes and delay loads. A behavioural model compares `freeze_n_o` and the readback against the design on every clock.

// File: rtl/frz_pkg.sv
package frz_pkg;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_DLY  = 1'b1
  } frz_reg_e;

endpackage

// File: rtl/frz_tick_gen.sv
module frz_tick_gen #(
  parameter int DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_pass
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= 1'b1;
      end
      assign tick_o = tick_q;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] pc_q, pc_d;
      logic          tick_q, tick_d;
      logic          wrap;

      assign wrap = (pc_q == LAST);

      always_comb begin
        pc_d   = wrap ? '0 : pc_q + 1'b1;
        tick_d = wrap;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pc_q   <= '0;
          tick_q <= 1'b0;
        end else begin
          pc_q   <= pc_d;
          tick_q <= tick_d;
        end
      end

      assign tick_o = tick_q;

      // tick is a single-cycle pulse when dividing (R7)
      p_tick_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
    end
  endgenerate

endmodule

// File: rtl/frz_arm.sv
module frz_arm #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_ctrl_i,
  input  logic [NSRC:0]   wdata_i,
  output logic            armed_o,
  output logic [NSRC-1:0] mask_o
);

  logic [NSRC-1:0] mask_q, mask_d;
  logic            armed_q, armed_d;
  logic [NSRC-1:0] hit;
  logic            any_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_qual
      assign hit[gi] = src_i[gi] & mask_q[gi];
    end
  endgenerate

  assign any_hit = |hit;

  always_comb begin
    mask_d  = mask_q;
    armed_d = armed_q;
    if (wr_ctrl_i) begin
      mask_d  = wdata_i[NSRC:1];
      armed_d = wdata_i[0];
    end else if (any_hit) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;
  assign mask_o  = mask_q;

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_i & mask_q)) && !wr_ctrl_i |=> armed_q);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !wr_ctrl_i |=> armed_q);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_i && !wdata_i[0] |=> !armed_q);

  p_noset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q && !wr_ctrl_i && ((src_i & mask_q) == '0) |=> !armed_q);

endmodule

// File: rtl/frz_delay.sv
module frz_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  output logic [DLY_W-1:0] cnt_o,
  output logic             zero_o
);

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             step_en;

  assign step_en = armed_i & tick_i & (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)       cnt_d = load_val_i;
    else if (step_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && !(armed_i && tick_i) |=> $stable(cnt_q));

  p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && armed_i && tick_i && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && (cnt_q == '0) |=> cnt_q == '0);

endmodule

// File: rtl/frz_trig_top.sv
module frz_trig_top
  import frz_pkg::*;
#(
  parameter int NSRC     = 3,
  parameter int DLY_W    = 16,
  parameter int DATA_W   = 16,
  parameter int TICK_DIV = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   trig_src_i,
  input  logic              host_wr_i,
  input  logic              host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              freeze_n_o
);

  localparam int CTRL_W   = NSRC + 1;
  localparam int CTRL_PAD = DATA_W - CTRL_W;
  localparam int DLY_PAD  = DATA_W - DLY_W;

  logic             rs1_q, rs2_q;
  logic             rst_int_n;
  logic             tick;
  logic             wr_ctrl, wr_dly;
  logic             armed;
  logic [NSRC-1:0]  mask;
  logic [DLY_W-1:0] cnt;
  logic             cnt_zero;
  logic [DATA_W-1:0] rd_ctrl, rd_dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  assign wr_ctrl = host_wr_i & (host_addr_i == REG_CTRL);
  assign wr_dly  = host_wr_i & (host_addr_i == REG_DLY);

  frz_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (tick)
  );

  frz_arm #(.NSRC(NSRC)) u_arm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .src_i     (trig_src_i),
    .wr_ctrl_i (wr_ctrl),
    .wdata_i   (host_wdata_i[NSRC:0]),
    .armed_o   (armed),
    .mask_o    (mask)
  );

  frz_delay #(.DLY_W(DLY_W)) u_dly (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .armed_i    (armed),
    .tick_i     (tick),
    .load_i     (wr_dly),
    .load_val_i (host_wdata_i[DLY_W-1:0]),
    .cnt_o      (cnt),
    .zero_o     (cnt_zero)
  );

  generate
    if (CTRL_PAD > 0) begin : g_ctrl_pad
      assign rd_ctrl = {{CTRL_PAD{1'b0}}, mask, armed};
    end else begin : g_ctrl_full
      assign rd_ctrl = {mask, armed};
    end
    if (DLY_PAD > 0) begin : g_dly_pad
      assign rd_dly = {{DLY_PAD{1'b0}}, cnt};
    end else begin : g_dly_full
      assign rd_dly = cnt;
    end
  endgenerate

  assign host_rdata_o = (host_addr_i == REG_DLY) ? rd_dly : rd_ctrl;
  assign freeze_n_o   = ~(armed & cnt_zero);

  // a freeze can only begin once the flag is set (R9)
  p_fall_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(freeze_n_o) |-> armed);

  // out of reset nothing is armed (R1)
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_int_n |-> freeze_n_o);

endmodule

// File: tb/frz_trig_top_bench.sv
module frz_trig_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC   = 3;
  localparam int DLY_W  = 16;
  localparam int DATA_W = 16;
  localparam int DIV    = 4;
  localparam int WATCHDOG_CYCLES = 100000;

  logic              clk;
  logic              rst_n;
  logic [NSRC-1:0]   src;
  logic              wr;
  logic              addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              freeze_n;

  frz_trig_top #(
    .NSRC(NSRC), .DLY_W(DLY_W), .DATA_W(DATA_W), .TICK_DIV(DIV)
  ) u_frz_trig_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_src_i   (src),
    .host_wr_i    (wr),
    .host_addr_i  (addr),
    .host_wdata_i (wdata),
    .host_rdata_o (rdata),
    .freeze_n_o   (freeze_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int m_s1, m_s2, m_pc, m_tick, m_flag, m_mask, m_cnt;
  int n_cmp, n_bad, n_cyc;
  bit done;
  string req;
  int unsigned rng;

  function automatic int unsigned rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic model_edge();
    int old_tick, old_flag;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pc = 0; m_tick = 0;
      m_flag = 0; m_mask = 0; m_cnt = 0;
      return;
    end
    if (m_s2 != 0) begin
      old_tick = m_tick;
      old_flag = m_flag;
      m_tick = (m_pc == DIV - 1) ? 1 : 0;
      m_pc   = (m_pc == DIV - 1) ? 0 : m_pc + 1;
      if (wr && addr == 1'b0) begin
        m_flag = int'(wdata[0]);
        m_mask = int'(wdata[3:1]);
      end else if ((int'(src) & m_mask) != 0) begin
        m_flag = 1;
      end
      if (wr && addr == 1'b1) m_cnt = int'(wdata);
      else if (old_flag != 0 && old_tick != 0 && m_cnt != 0) m_cnt = m_cnt - 1;
    end
    m_s2 = m_s1;
    m_s1 = 1;
  endtask

  task automatic compare();
    int exp_frz, exp_rd;
    exp_frz = (m_flag != 0 && m_cnt == 0) ? 0 : 1;
    exp_rd  = addr ? m_cnt : ((m_mask << 1) | m_flag);
    n_cmp++;
    if (int'(freeze_n) != exp_frz) begin
      n_bad++;
      $display("FAIL %s freeze_n actual=%0d expected=%0d at %0t", req, freeze_n, exp_frz, $time);
    end
    n_cmp++;
    if (int'(rdata) != exp_rd) begin
      n_bad++;
      $display("FAIL %s rdata(addr=%0d) actual=%0h expected=%0h at %0t", req, addr, rdata, exp_rd, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    model_edge();
    compare();
    n_cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      wr = 1'b0;
      cyc();
    end
  endtask

  task automatic hwrite(input logic a, input int d);
    wr = 1'b1; addr = a; wdata = DATA_W'(d);
    cyc();
    wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    rng = 32'h1234_5678;
    n_cmp = 0; n_bad = 0; n_cyc = 0; done = 1'b0;
    rst_n = 1'b0; src = '0; wr = 1'b0; addr = 1'b0; wdata = '0;
    m_s1 = 0; m_s2 = 0; m_pc = 0; m_tick = 0; m_flag = 0; m_mask = 0; m_cnt = 0;

    // R1: reset values on both registers and the output
    req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(4);
    addr = 1'b1; idle(2); addr = 1'b0; idle(2);

    // R5 R10: mask enables source 0 only, readback layout
    req = "R5/R10";
    hwrite(1'b0, 32'h2);
    // R6: load delay 3
    req = "R6";
    hwrite(1'b1, 3);
    addr = 1'b1; idle(2);

    // R2 R7 R9: enabled source pulse, delayed freeze
    req = "R2";
    src = 3'b001; idle(1); src = '0;
    req = "R7/R9";
    idle(20);
    // R4 R8: flag sticky, counter parked at zero
    req = "R4/R8";
    idle(12);
    addr = 1'b0; idle(2);

    // R5: all-zero write clears flag and mask
    req = "R5";
    hwrite(1'b0, 0);
    src = 3'b111; idle(4); src = '0; idle(2);

    // R3: masked source ignored
    req = "R3";
    hwrite(1'b0, 32'h4);
    src = 3'b101; idle(6);
    addr = 1'b1; idle(3); addr = 1'b0;
    src = 3'b010; idle(1); src = '0;
    // R9: zero delay freezes at once
    req = "R9";
    idle(4);

    // R6 R7: reload while flag set, countdown resumes
    req = "R6/R7";
    hwrite(1'b1, 5);
    addr = 1'b1; idle(30);

    // R9: host set applies the delay too
    req = "R9";
    hwrite(1'b0, 0);
    hwrite(1'b1, 2);
    hwrite(1'b0, 1);
    idle(14);

    // R5: clearing write wins over an enabled source in the same cycle
    req = "R5";
    hwrite(1'b0, 32'h8);
    src = 3'b100;
    hwrite(1'b0, 32'h8);
    idle(3);
    src = '0;
    hwrite(1'b0, 0);
    idle(2);

    // mixed pseudo-random phase covering R2 R3 R4 R5 R6 R7 R8 R9 R10
    req = "R2-R10 mix";
    for (int k = 0; k < 3000; k++) begin
      int unsigned r;
      r = rnd();
      src  = ((r & 32'h1F) == 0) ? NSRC'(r >> 8) : '0;
      addr = r[12];
      if ((r >> 16) % 23 == 0) begin
        wr = 1'b1;
        wdata = addr ? DATA_W'((r >> 20) & 7) : DATA_W'((r >> 20) & 15);
      end else begin
        wr = 1'b0;
      end
      cyc();
    end
    wr = 1'b0;
    idle(2);
    finish_run();
  end

  initial begin
    for (int w = 0; w < WATCHDOG_CYCLES; w++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d cycles expected=completion", WATCHDOG_CYCLES);
    finish_run();
  end

endmodule